// File: doc/BRIEF.md
# Programming-Status Read Responder

This block sits in the read path of a byte-wide nonvolatile store whose programming phase runs on its own timer. It notes every byte handed to the store for programming (address and value) and watches the read strobes. While the programming-busy flag is high, a read does not return array contents verbatim. Instead, the top data bit answers with the inverse of the bit last written there, and the next bit down changes value once per read cycle. The host can poll either bit to see when programming is over.

A read cycle exists only while both active-low select and active-low output-enable are asserted. Outside such a cycle the output driver is disabled and the data output is held at zero. A read cycle is counted once, at the cycle in which the combined read enable first becomes active, and not once per clock. As soon as the busy flag drops, reads return the array data again.

Top module: `prog_status_rd`

## Requirements
- R1: When `sel_n` or `oen_n` is high, `rd_oe` is 0 and `rd_data` is all zeros; when both are low, `rd_oe` is 1.
- R2: During a read with `busy_i` high and `addr` equal to the last captured write address, `rd_data[7]` is the inverse of bit 7 of the last captured write data; with any other address it is `arr_rdata[7]`.
- R3: During a read with `busy_i` low, `rd_data` equals `arr_rdata` on all bits.
- R4: During a read with `busy_i` high, `rd_data[6]` keeps one value for the whole read cycle, and two consecutive such read cycles give opposite values.
- R5: While `busy_i` is low the toggle state does not advance, so reads made then leave the alternation of later busy reads unbroken, and `rd_data[6]` follows `arr_rdata[6]`.
- R6: During a read with `busy_i` high, `rd_data[5:0]` are zero.
- R7: A clock with `wr_stb` high captures `wr_addr` and `wr_data`; they appear on `last_addr_o` and `last_data_o` from the next cycle, and `busy_o` mirrors `busy_i`.
- R8: After reset, `last_addr_o` and `last_data_o` are zero and no output is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Active-low chip select |
| oen_n | input | 1 | Active-low output enable |
| addr | input | 15 | Read address |
| arr_rdata | input | 8 | Data read from the array |
| busy_i | input | 1 | Programming phase in progress |
| wr_stb | input | 1 | Capture of a byte sent for programming |
| wr_addr | input | 15 | Address of the captured byte |
| wr_data | input | 8 | Value of the captured byte |
| rd_data | output | 8 | Read data or status |
| rd_oe | output | 1 | Output driver enable |
| busy_o | output | 1 | Copy of the busy flag |
| last_addr_o | output | 15 | Last captured write address |
| last_data_o | output | 8 | Last captured write data |

## Verification
The hardest case is the toggle bit. Its starting value is not defined, and it must stay steady across a long read yet flip between reads. The stimulus therefore holds reads for several clocks with idle gaps between them. It also places non-busy reads between two busy windows. The reference model compares each busy read only with the previous busy read, never with an absolute value.

// File: rtl/prog_status_rd.sv
module prog_status_rd #(
  parameter int AW = 15,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_n,
  input  logic          oen_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] arr_rdata,
  input  logic          busy_i,
  input  logic          wr_stb,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          rd_oe,
  output logic          busy_o,
  output logic [AW-1:0] last_addr_o,
  output logic [DW-1:0] last_data_o
);
  localparam int PB = DW - 1;
  localparam int TB = DW - 2;

  logic          rd_en, rd_en_q, rd_start, tog;
  logic [DW-1:0] status;

  assign rd_en    = !sel_n && !oen_n;
  assign rd_start = rd_en && !rd_en_q;
  assign rd_oe    = rd_en;
  assign busy_o   = busy_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_en_q     <= 1'b0;
      tog         <= 1'b0;
      last_addr_o <= '0;
      last_data_o <= '0;
    end else begin
      rd_en_q <= rd_en;
      if (busy_i && rd_start) tog <= !tog;
      if (wr_stb) begin
        last_addr_o <= wr_addr;
        last_data_o <= wr_data;
      end
    end
  end

  always_comb begin
    status     = '0;
    status[PB] = (addr == last_addr_o) ? !last_data_o[PB] : arr_rdata[PB];
    status[TB] = busy_i && rd_start ? !tog : tog;
  end

  assign rd_data = !rd_en ? '0 : (busy_i ? status : arr_rdata);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n || oen_n) |-> (!rd_oe && rd_data == '0)); // R1
  AST_POLL_INV: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy_i && addr == last_addr_o) |-> (rd_data[PB] != last_data_o[PB])); // R2
  AST_DONE_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !busy_i) |-> (rd_data == arr_rdata)); // R3
  AST_TOG_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rd_en) && busy_i && $past(busy_i)) |-> $stable(rd_data[TB])); // R4
  AST_TOG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_i |=> $stable(tog)); // R5
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy_i) |-> (rd_data[TB-1:0] == '0)); // R6
  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> (last_addr_o == $past(wr_addr) && last_data_o == $past(wr_data))); // R7
endmodule

// File: tb/prog_status_rd_tb.sv
module prog_status_rd_tb;
  logic        clk = 0, rst_n = 0;
  logic        sel_n = 1, oen_n = 1, busy_i = 0, wr_stb = 0;
  logic [14:0] addr = '0, wr_addr = '0;
  logic [7:0]  arr_rdata = '0, wr_data = '0;
  logic [7:0]  rd_data;
  logic        rd_oe, busy_o;
  logic [14:0] last_addr_o;
  logic [7:0]  last_data_o;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = !clk;

  prog_status_rd u_dut (.clk, .rst_n, .sel_n, .oen_n, .addr, .arr_rdata, .busy_i,
    .wr_stb, .wr_addr, .wr_data, .rd_data, .rd_oe, .busy_o, .last_addr_o, .last_data_o);

  // reference model state
  logic [14:0] m_addr = '0;
  logic [7:0]  m_data = '0;
  bit          m_prev_en = 0;
  bit          have_prev = 0, prev_seen = 0, cur_val = 0, in_busy_read = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_addr <= '0; m_data <= '0; m_prev_en <= 0;
    end else begin
      m_prev_en <= !sel_n && !oen_n;
      if (wr_stb) begin m_addr <= wr_addr; m_data <= wr_data; end
    end
  end

  always @(negedge clk) begin
    bit en;
    logic [7:0] exp;
    en = !sel_n && !oen_n;
    if (!rst_n) begin
      chk(rd_oe == 0 && rd_data == 0, "R8 rst outputs", {rd_oe, rd_data}, 0);
      chk(last_addr_o == 0 && last_data_o == 0, "R8 rst regs", last_data_o, 0);
    end else begin
      chk(busy_o == busy_i, "R7 busy_o", busy_o, busy_i);
      chk(last_addr_o == m_addr && last_data_o == m_data, "R7 capture",
          {last_addr_o, last_data_o}, {m_addr, m_data});
      if (!en) begin
        chk(rd_oe == 0 && rd_data == 0, "R1 idle", {rd_oe, rd_data}, 0);
        if (in_busy_read) begin prev_seen = cur_val; have_prev = 1; in_busy_read = 0; end
      end else if (!busy_i) begin
        chk(rd_oe == 1, "R1 oe", rd_oe, 1);
        chk(rd_data == arr_rdata, "R3/R5 true data", rd_data, arr_rdata);
      end else begin
        exp = 8'h00;
        exp[7] = (addr == m_addr) ? !m_data[7] : arr_rdata[7];
        chk(rd_data[7] == exp[7], "R2 poll bit", rd_data[7], exp[7]);
        chk(rd_data[5:0] == 0, "R6 reserved", rd_data[5:0], 0);
        if (!m_prev_en) begin
          if (have_prev) chk(rd_data[6] != prev_seen, "R4/R5 alternate", rd_data[6], !prev_seen);
          cur_val = rd_data[6];
          in_busy_read = 1;
        end else begin
          chk(rd_data[6] == cur_val, "R4 steady", rd_data[6], cur_val);
        end
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic capture(input logic [14:0] a, input logic [7:0] d);
    wr_addr = a; wr_data = d; wr_stb = 1; cyc(1); wr_stb = 0;
  endtask

  task automatic rd(input logic [14:0] a, input logic [7:0] arr, input int len);
    addr = a; arr_rdata = arr; sel_n = 0; oen_n = 0; cyc(len);
    sel_n = 1; oen_n = 1; cyc(2);
  endtask

  initial begin
    cyc(3);
    rst_n = 1; cyc(2);
    capture(15'h1234, 8'h35);
    rd(15'h1234, 8'hC3, 2);
    busy_i = 1; cyc(1);
    for (int i = 0; i < 5; i++) rd(15'h1234, 8'h5A ^ 8'(i), 1 + i);
    rd(15'h0777, 8'hFF, 2);
    rd(15'h0777, 8'h40, 1);
    sel_n = 0; oen_n = 1; cyc(2);
    sel_n = 1; oen_n = 0; cyc(2);
    oen_n = 1; cyc(1);
    busy_i = 0; cyc(1);
    rd(15'h1234, 8'h6E, 3);
    rd(15'h0001, 8'h81, 1);
    capture(15'h7FFF, 8'hA0);
    busy_i = 1; cyc(1);
    for (int i = 0; i < 4; i++) rd(15'h7FFF, 8'h3C, 2);
    addr = 15'h7FFF; sel_n = 0; oen_n = 0; cyc(1);
    addr = 15'h0100; arr_rdata = 8'h80; cyc(2);
    sel_n = 1; oen_n = 1; cyc(2);
    busy_i = 0; cyc(1);
    rd(15'h7FFF, 8'hA5, 2);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (5000) @(posedge clk); end
    join_any
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule